// File: doc/BRIEF.md
# 24-Bit System Tick Timer

A register-mapped periodic timer for a processor subsystem. It holds a 24-bit down-counter that can step once per core-clock cycle or once per rising edge of a slower reference clock. That reference clock arrives asynchronously and is synchronized inside the block. When a count event finds the counter at zero, the counter reloads from a programmable reload register. Each step from one to zero sets a sticky wrap flag. If enabled, that step also fires a single-cycle interrupt request.

Software reaches the timer through four word-wide registers on a simple register bus: control/status, reload, current value and a read-only calibration word. The calibration word is fixed by parameters. It tells software whether a reference clock exists, whether the ten-millisecond figure is exact, and how many reference ticks make up ten milliseconds. The block has no bus bridge and no interrupt controller. It presents one request line.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word reads 0, except that bit 2 reads 1 when no reference clock is configured. Reload and current value read 0, and the interrupt line is low.
- R2: Byte offsets decode as follows: 0x0 control, 0x4 reload, 0x8 current value, 0xC calibration. Reads of reload and current value return the 24-bit field with bits 31:24 as zero, so a reload write of 0xFFFFFFFF reads back as 0x00FFFFFF.
- R3: While control bit 0 is 0, the counter keeps its value.
- R4: With control bit 0 = 1 and control bit 2 = 1, the counter decrements by one on every core-clock cycle.
- R5: With control bit 0 = 1 and control bit 2 = 0, the counter steps once per rising edge of the reference clock, seen through a two-flop synchronizer. It does not step on core-clock cycles with no such edge.
- R6: A count event that finds the counter at 0 loads the reload value instead of decrementing. A reload value of 0 therefore keeps the counter at 0.
- R7: A write of any data to offset 0x8 sets the counter to 0 and clears the wrap flag.
- R8: Control bit 16 is a wrap flag. It is set when the counter steps from 1 to 0, and it is cleared by a read of the control word. That read still returns the flag as set, and a set in the same cycle wins.
- R9: When control bit 1 = 1, each step from 1 to 0 raises the interrupt line for exactly one core-clock cycle. When control bit 1 = 0, the line stays low.
- R10: The calibration word is read-only and ignores writes. Bit 31 is the no-reference flag, bit 30 is the inexact flag, and bits 23:0 are the ten-millisecond tick count. All three come from parameters.
- R11: When the no-reference parameter is set, control bit 2 reads 1 whatever is written, and only the core clock drives counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refClk | input | 1 | Asynchronous reference clock |
| regSel | input | 1 | Register access valid this cycle |
| regWr | input | 1 | 1 = write, 0 = read |
| regAddr | input | 4 | Byte offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the access cycle, zero otherwise |
| irqOut | output | 1 | Single-cycle interrupt request |

## Verification
A wrong counter value shows at the current-value register at the next read. It also shifts the irq pulse away from the cycle after the event that should have stepped the counter from 1 to 0, so the number of pulses over a known run of events changes. A wrap flag that fails to set or clear shows at the next control read. A synchronizer that double-counts or misses reference edges leaves the counter off by the number of pulses after a short burst of reference edges. A calibration or source-select bit that is not held shows on the first read after a write to it.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [1:0] {
    SLOT_CTRL    = 2'd0,
    SLOT_RELOAD  = 2'd1,
    SLOT_CURRENT = 2'd2,
    SLOT_CALIB   = 2'd3
  } regSlot_e;

  localparam int unsigned BIT_ENABLE = 0;
  localparam int unsigned BIT_IRQEN  = 1;
  localparam int unsigned BIT_SRC    = 2;
  localparam int unsigned BIT_WRAP   = 16;
  localparam int unsigned BIT_NOREF  = 31;
  localparam int unsigned BIT_SKEW   = 30;

  typedef struct packed {
    logic countEvt;
    logic curWrite;
    logic reloadWrite;
    logic ctlRead;
    logic irqArm;
  } tickStrobe_t;
endpackage

// File: rtl/tick_timer_refsync.sv
module tick_timer_refsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic refIn,
  output logic riseEvt
);
  localparam int unsigned LAST = STAGES;

  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[LAST-1:0], refIn};
  end

  assign riseEvt = chain[LAST-1] & ~chain[LAST];
endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 24,
  parameter bit          NO_REF      = 1'b0,
  parameter bit          CAL_INEXACT = 1'b1,
  parameter int unsigned TENMS_TICKS = 2500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  input  logic              refRise,
  input  logic [CNT_W-1:0]  curCount,
  input  logic [CNT_W-1:0]  reloadVal,
  input  logic              wrapFlag,
  output tickStrobe_t       strobe,
  output logic [WORD_W-1:0] regRdata,
  output logic              ctlEnable,
  output logic              ctlSrcCore
);
  localparam logic [CNT_W-1:0] TENMS_FIELD = TENMS_TICKS[CNT_W-1:0];

  regSlot_e slot;
  logic     wordHit;
  logic     wrCtl;
  logic     rdCtl;
  logic     ctlIrqEn;
  logic     unusedWdata;

  assign slot    = regSlot_e'(regAddr[3:2]);
  assign wordHit = regSel && (regAddr[1:0] == 2'b00);
  assign wrCtl   = wordHit && regWr && (slot == SLOT_CTRL);
  assign rdCtl   = wordHit && !regWr && (slot == SLOT_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlEnable <= 1'b0;
      ctlIrqEn  <= 1'b0;
    end else if (wrCtl) begin
      ctlEnable <= regWdata[BIT_ENABLE];
      ctlIrqEn  <= regWdata[BIT_IRQEN];
    end
  end

  generate
    if (NO_REF) begin : g_coreOnly
      assign ctlSrcCore = 1'b1;
    end else begin : g_srcSelect
      logic srcReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      srcReg <= 1'b0;
        else if (wrCtl) srcReg <= regWdata[BIT_SRC];
      end
      assign ctlSrcCore = srcReg;
    end
  endgenerate

  assign unusedWdata = ^{regWdata[WORD_W-1:BIT_SRC+1]};

  always_comb begin
    strobe             = '0;
    strobe.countEvt    = ctlEnable && (ctlSrcCore || refRise);
    strobe.curWrite    = wordHit && regWr && (slot == SLOT_CURRENT);
    strobe.reloadWrite = wordHit && regWr && (slot == SLOT_RELOAD);
    strobe.ctlRead     = rdCtl;
    strobe.irqArm      = ctlIrqEn;
  end

  always_comb begin
    regRdata = '0;
    if (wordHit && !regWr) begin
      unique case (slot)
        SLOT_CTRL: begin
          regRdata[BIT_ENABLE] = ctlEnable;
          regRdata[BIT_IRQEN]  = ctlIrqEn;
          regRdata[BIT_SRC]    = ctlSrcCore;
          regRdata[BIT_WRAP]   = wrapFlag;
        end
        SLOT_RELOAD:  regRdata[CNT_W-1:0] = reloadVal;
        SLOT_CURRENT: regRdata[CNT_W-1:0] = curCount;
        SLOT_CALIB: begin
          regRdata[BIT_NOREF]   = NO_REF;
          regRdata[BIT_SKEW]    = CAL_INEXACT;
          regRdata[CNT_W-1:0]   = TENMS_FIELD;
        end
        default: regRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  tickStrobe_t      strobe,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] curCount,
  output logic [CNT_W-1:0] reloadVal,
  output logic             wrapFlag,
  output logic             irqOut
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic atZero;
  logic hitZero;

  assign atZero  = (curCount == '0);
  assign hitZero = strobe.countEvt && (curCount == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   reloadVal <= '0;
    else if (strobe.reloadWrite) reloadVal <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCount <= '0;
      wrapFlag <= 1'b0;
      irqOut   <= 1'b0;
    end else begin
      irqOut <= 1'b0;
      if (strobe.curWrite) begin
        curCount <= '0;
        wrapFlag <= 1'b0;
      end else begin
        if (strobe.countEvt) begin
          if (atZero) curCount <= reloadVal;
          else        curCount <= curCount - ONE;
        end
        if (hitZero) begin
          wrapFlag <= 1'b1;
          irqOut   <= strobe.irqArm;
        end else if (strobe.ctlRead) begin
          wrapFlag <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          NO_REF      = 1'b0,
  parameter bit          CAL_INEXACT = 1'b1,
  parameter int unsigned TENMS_TICKS = 2500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refClk,
  input  logic              regSel,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  output logic              irqOut
);
  tickStrobe_t      strobe;
  logic             refRise;
  logic [CNT_W-1:0] curCount;
  logic [CNT_W-1:0] reloadVal;
  logic             wrapFlag;
  logic             ctlEnable;
  logic             ctlSrcCore;

  tick_timer_refsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .refIn   (refClk),
    .riseEvt (refRise)
  );

  tick_timer_ctrl #(
    .CNT_W       (CNT_W),
    .NO_REF      (NO_REF),
    .CAL_INEXACT (CAL_INEXACT),
    .TENMS_TICKS (TENMS_TICKS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regSel     (regSel),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .refRise    (refRise),
    .curCount   (curCount),
    .reloadVal  (reloadVal),
    .wrapFlag   (wrapFlag),
    .strobe     (strobe),
    .regRdata   (regRdata),
    .ctlEnable  (ctlEnable),
    .ctlSrcCore (ctlSrcCore)
  );

  tick_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wdata     (regWdata[CNT_W-1:0]),
    .curCount  (curCount),
    .reloadVal (reloadVal),
    .wrapFlag  (wrapFlag),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             regSel,
  input logic             regWr,
  input logic [3:0]       regAddr,
  input logic [31:0]      regRdata,
  input logic             irqOut,
  input logic [CNT_W-1:0] curCount,
  input logic             wrapFlag,
  input logic             ctlEnable,
  input logic             ctlSrcCore
);
  logic curWr;
  logic cntRd;
  assign curWr = regSel && regWr && (regAddr == 4'h8);
  assign cntRd = regSel && !regWr && ((regAddr == 4'h4) || (regAddr == 4'h8));

  p_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    cntRd |-> (regRdata[31:CNT_W] == '0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlEnable && !curWr) |=> $stable(curCount));

  p_core_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctlEnable && ctlSrcCore && (curCount != '0) && !curWr)
      |=> (curCount == $past(curCount) - CNT_W'(1)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    curWr |=> ((curCount == '0) && !wrapFlag));

  p_irq_at_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((curCount == '0) && wrapFlag));

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |=> !irqOut);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regSel     (regSel),
  .regWr      (regWr),
  .regAddr    (regAddr),
  .regRdata   (regRdata),
  .irqOut     (irqOut),
  .curCount   (curCount),
  .wrapFlag   (wrapFlag),
  .ctlEnable  (ctlEnable),
  .ctlSrcCore (ctlSrcCore)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
  localparam real CLK_HALF = 2.0;

  typedef struct {
    int          kind;   // 0: u0 read, 1: u1 read, 2: irq pulse count, 3: longest irq run
    logic [31:0] exp;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refClk = 1'b0;
  logic        regSel = 1'b0;
  logic        regWr = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] rdA, rdB;
  logic        irqA, irqB;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int irqPulses = 0;
  int irqRun = 0;
  int irqMaxRun = 0;

  expItem_t expQ[$];
  event     sampleEv;

  always #(CLK_HALF) clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rstN(rstN), .refClk(refClk), .regSel(regSel), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(rdA), .irqOut(irqA)
  );

  tick_timer #(.NO_REF(1'b1), .CAL_INEXACT(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .refClk(refClk), .regSel(regSel), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(rdB), .irqOut(irqB)
  );

  // irq observer
  always @(negedge clk) begin
    if (rstN) begin
      if (irqA) begin
        if (irqRun == 0) irqPulses++;
        irqRun++;
        if (irqRun > irqMaxRun) irqMaxRun = irqRun;
      end else begin
        irqRun = 0;
      end
    end
  end

  // scoreboard monitor
  always @(sampleEv) begin
    expItem_t it;
    logic [31:0] got;
    it = expQ.pop_front();
    case (it.kind)
      0: got = rdA;
      1: got = rdB;
      2: got = 32'(irqPulses);
      default: got = 32'(irqMaxRun);
    endcase
    checks++;
    if (got !== it.exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regSel = 1'b1; regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input int which, input logic [3:0] a, input logic [31:0] e, input string tag);
    expItem_t it;
    it.kind = which; it.exp = e; it.tag = tag;
    expQ.push_back(it);
    regSel = 1'b1; regWr = 1'b0; regAddr = a;
    #1;
    ->sampleEv;
    @(negedge clk);
    regSel = 1'b0;
  endtask

  task automatic expectStat(input int kind, input int e, input string tag);
    expItem_t it;
    it.kind = kind; it.exp = 32'(e); it.tag = tag;
    expQ.push_back(it);
    #1;
    ->sampleEv;
    @(negedge clk);
  endtask

  // n count events on the core clock, then counting left disabled
  task automatic runCore(input logic [31:0] bits, input int n);
    wr(4'h0, bits | 32'h1);
    repeat (n - 1) @(negedge clk);
    wr(4'h0, bits & ~32'h1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 2 * CLK_HALF);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state, R10/R11 calibration words
    rd(0, 4'h0, 32'h0000_0000, "R1 ctrl after reset");
    rd(0, 4'h4, 32'h0000_0000, "R1 reload after reset");
    rd(0, 4'h8, 32'h0000_0000, "R1 current after reset");
    expectStat(2, 0, "R1 no irq after reset");
    rd(0, 4'hC, 32'h4000_09C4, "R10 calibration word");
    rd(1, 4'h0, 32'h0000_0004, "R11 no-ref ctrl after reset");
    rd(1, 4'hC, 32'h8000_09C4, "R11 no-ref calibration word");

    // R2 upper bits dropped
    wr(4'h4, 32'hAB12_3456);
    rd(0, 4'h4, 32'h0012_3456, "R2 reload upper bits zero");

    // R11 source bit stuck at core
    wr(4'h0, 32'h1);
    rd(1, 4'h0, 32'h0000_0005, "R11 source forced to core");
    wr(4'h0, 32'h0);

    // R4 core-clock stepping, R3 hold while disabled
    wr(4'h4, 32'd5);
    runCore(32'h4, 3);
    repeat (10) @(negedge clk);
    rd(0, 4'h8, 32'd3, "R3 R4 count after 3 events then hold");
    runCore(32'h4, 3);
    rd(0, 4'h8, 32'd0, "R4 count reaches zero");

    // R8 wrap flag set then cleared by a control read
    rd(0, 4'h0, 32'h0001_0004, "R8 wrap flag set");
    rd(0, 4'h0, 32'h0000_0004, "R8 wrap flag cleared by read");

    // R6 reload on event at zero
    runCore(32'h4, 1);
    rd(0, 4'h8, 32'd5, "R6 reload from zero");

    // R7 any write clears the counter
    wr(4'h8, 32'hDEAD_BEEF);
    rd(0, 4'h8, 32'd0, "R7 current cleared by write");

    // R9 interrupt pulses
    wr(4'h4, 32'd2);
    runCore(32'h6, 6);
    @(negedge clk);
    expectStat(2, 2, "R9 two irq pulses");
    expectStat(3, 1, "R9 irq one cycle wide");
    rd(0, 4'h0, 32'h0001_0006, "R8 flag after irq run");
    runCore(32'h4, 6);
    @(negedge clk);
    expectStat(2, 2, "R9 no irq when disabled");
    rd(0, 4'h0, 32'h0001_0004, "R8 flag without irq enable");

    // R6 reload of zero keeps counter stopped
    wr(4'h4, 32'd0);
    wr(4'h8, 32'd0);
    runCore(32'h4, 5);
    rd(0, 4'h8, 32'd0, "R6 zero reload stays at zero");
    rd(0, 4'h0, 32'h0000_0004, "R6 no wrap with zero reload");

    // R7 write clears the wrap flag
    wr(4'h4, 32'd1);
    runCore(32'h4, 2);
    wr(4'h8, 32'h0000_0123);
    rd(0, 4'h0, 32'h0000_0004, "R7 wrap flag cleared by current write");

    // R5 reference-clock stepping
    wr(4'h4, 32'd10);
    wr(4'h8, 32'd0);
    wr(4'h0, 32'h1);
    repeat (8) @(negedge clk);
    rd(0, 4'h8, 32'd0, "R5 no core-clock steps in reference mode");
    for (int i = 0; i < 4; i++) begin
      #7.3 refClk = 1'b1;
      #21.1 refClk = 1'b0;
      #19.7;
    end
    @(negedge clk);
    repeat (6) @(negedge clk);
    wr(4'h0, 32'h0);
    rd(0, 4'h8, 32'd7, "R5 four reference edges");

    // R10 calibration ignores writes
    wr(4'hC, 32'hFFFF_FFFF);
    rd(0, 4'hC, 32'h4000_09C4, "R10 calibration unchanged by write");

    // R2 largest reload
    wr(4'h4, 32'hFFFF_FFFF);
    rd(0, 4'h4, 32'h00FF_FFFF, "R2 maximum reload");
    wr(4'h8, 32'd0);
    runCore(32'h4, 1);
    rd(0, 4'h8, 32'h00FF_FFFF, "R2 R6 current after max reload");

    done = 1;
    summary();
    $finish;
  end
endmodule